// File: doc/BRIEF.md
# Two-Wire Dual Wiper Register Controller

This block is a slave on a two-wire serial bus that owns two 8-bit wiper position registers. A downstream tap decoder reads the registers at its outputs. The bus lines are oversampled by a system clock at least eight times faster than the serial clock. START, repeated START and STOP are detected on the sampled lines. The data line is driven only through an open-drain style enable, so the enable pulls the line low and its absence leaves the line released.

A transfer opens with a control byte. Its upper four bits must equal the identifier 4'b0101 and its next three bits must equal the live device-select pins. Its last bit chooses read (1) or write (0). A write then carries a command byte and data bytes. A read returns wiper 0, then wiper 1, then a filler value.

The controller is a single state machine with ten states:
- IDLE: the bus is free.
- CTRL: shifting in the control byte.
- CTRL_ACK: acknowledging the control byte.
- CMD: shifting in the command byte.
- CMD_ACK: acknowledging the command byte.
- WDATA: shifting in a data byte.
- WDATA_ACK: acknowledging a data byte.
- RDATA: shifting a byte out.
- RACK: sampling the master's acknowledge.
- IGNORE: silent until the next START or STOP.

A START moves any state to CTRL. A STOP moves any state to IDLE. After eight bits, CTRL goes to CTRL_ACK on an address match and to IGNORE otherwise. CMD goes to CMD_ACK on a known command and to IGNORE otherwise. WDATA always goes to WDATA_ACK. CTRL_ACK goes to RDATA for a read and to CMD for a write. CMD_ACK and WDATA_ACK both go to WDATA. RDATA goes to RACK after eight bits. RACK goes to RDATA when the master acknowledged and to IGNORE when it did not.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: A data-line fall while the clock line is high (START) begins a control-byte phase from any state. A data-line rise while the clock line is high (STOP) returns to IDLE with the data line released. Bytes clocked after a STOP and without a new START are not acknowledged.
- R2: The control byte is received MSB first. Bits 7..4 must be 4'b0101 and bits 3..1 must equal the select pins. On a match the slave pulls the data line low for the ninth clock. On a mismatch it does not, and it stays silent until the next START or STOP.
- R3: The select-pin comparison uses the pin values present when the control byte completes, so a pin change between transfers takes effect at once.
- R4: Every byte moves MSB first. The receiver drives the acknowledge from the clock fall that ends bit 8 until the clock fall that ends bit 9.
- R5: In a write, command 8'hA9 sends the first data byte to wiper 0. Command 8'hAA sends it to wiper 1. Command 8'hAF loads it into both wipers.
- R6: After command 8'hA9, a second data byte loads wiper 1.
- R7: Reset clears both wipers to 8'h00 and releases the data line.
- R8: A command byte other than A9, AA or AF is not acknowledged. Later bytes up to the next START or STOP are neither acknowledged nor stored.
- R9: Write data bytes beyond the defined count are acknowledged and change no wiper.
- R10: A read returns wiper 0, then wiper 1, then 8'hFF for every later byte.
- R11: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing until the next START.
- R12: A repeated START with no STOP in between ends the current transfer and accepts a new control byte.
- R13: The data-line enable and the wiper outputs change only while the synchronized clock line is low, after a clock fall has been detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_sel_i | input | 3 | Device-select pins, compared live |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wiper0_o | output | 8 | Wiper 0 position |
| wiper1_o | output | 8 | Wiper 1 position |

## Verification
The hardest condition to reach from the ports is the silent state after a rejected command or a master NACK. Nothing at the outputs marks it, so its effect has to be made visible. The stimulus keeps clocking full bytes after the rejection. It then checks that no acknowledge appears and that the read-back bytes are all ones, where an active slave would have returned wiper 1. Reads past wiper 1 are reached by acknowledging every byte through the third slot.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int IDX_W  = 2;
    localparam int N_WIPER = 2;

    localparam logic [3:0]        DEV_ID   = 4'b0101;
    localparam logic [BYTE_W-1:0] CMD_W0   = 8'hA9;
    localparam logic [BYTE_W-1:0] CMD_W1   = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_BOTH = 8'hAF;
    localparam logic [BYTE_W-1:0] RD_FILL  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_CMD, ST_CMD_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE
    } bus_state_e;

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == CMD_W0) || (c == CMD_W1) || (c == CMD_BOTH);
    endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_lvl;
            sda_q  <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/wr_target_dec.sv
module wr_target_dec
    import wiper_pkg::*;
(
    input  logic [BYTE_W-1:0]  cmd,
    input  logic [IDX_W-1:0]   idx,
    output logic [N_WIPER-1:0] ld_mask
);
    always_comb begin
        ld_mask = '0;
        unique case (cmd)
            CMD_W0: begin
                if (idx == 2'd0) ld_mask = 2'b01;
                else if (idx == 2'd1) ld_mask = 2'b10;
            end
            CMD_W1:   if (idx == 2'd0) ld_mask = 2'b10;
            CMD_BOTH: if (idx == 2'd0) ld_mask = 2'b11;
            default:  ld_mask = '0;
        endcase
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] wq [N]
);
    for (genvar i = 0; i < N; i++) begin : g_wiper
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     wq[i] <= '0;
            else if (ld[i]) wq[i] <= din;
        end
    end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_sel_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] wiper0_o,
    output logic [BYTE_W-1:0] wiper1_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(2);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    tw_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    bus_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q, cmd_q, tx_q, rd_next;
    logic [IDX_W-1:0]  idx_q, idx_inc;
    logic              rw_q, mack_q, oe_q;
    logic              bit_full, id_hit, end_byte;
    logic [N_WIPER-1:0] ld_mask, ld_en;
    logic [BYTE_W-1:0] wq [N_WIPER];

    assign bit_full = (bitcnt_q == FULL_CNT);
    assign end_byte = scl_fall & bit_full;
    assign id_hit   = (shreg_q[BYTE_W-1:1] == {DEV_ID, dev_sel_i});
    assign idx_inc  = (idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1;

    always_comb begin
        unique case (idx_q)
            2'd0:    rd_next = wq[0];
            2'd1:    rd_next = wq[1];
            default: rd_next = RD_FILL;
        endcase
    end

    wr_target_dec dec_i (.cmd(cmd_q), .idx(idx_q), .ld_mask(ld_mask));

    assign ld_en = (state_q == ST_WDATA && end_byte && !start_evt && !stop_evt)
                   ? ld_mask : '0;

    wiper_bank #(.W(BYTE_W), .N(N_WIPER)) bank_i (
        .clk(clk), .rst_n(rst_n), .ld(ld_en), .din(shreg_q), .wq(wq)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_CTRL;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_CTRL:      if (end_byte) state_d = id_hit ? ST_CTRL_ACK : ST_IGNORE;
                ST_CMD:       if (end_byte) state_d = cmd_known(shreg_q) ? ST_CMD_ACK : ST_IGNORE;
                ST_WDATA:     if (end_byte) state_d = ST_WDATA_ACK;
                ST_CTRL_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD_ACK,
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (end_byte) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            cmd_q    <= '0;
            tx_q     <= '0;
            idx_q    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (start_evt) begin
            bitcnt_q <= '0;
            idx_q    <= '0;
            oe_q     <= 1'b0;
        end else if (stop_evt) begin
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CTRL, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_lvl};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (end_byte) begin
                        if (state_q == ST_CTRL) begin
                            oe_q <= id_hit;
                            rw_q <= shreg_q[0];
                        end else if (state_q == ST_CMD) begin
                            oe_q  <= cmd_known(shreg_q);
                            cmd_q <= shreg_q;
                            idx_q <= '0;
                        end else begin
                            oe_q  <= 1'b1;
                            idx_q <= idx_inc;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q     <= 1'b0;
                        bitcnt_q <= '0;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        bitcnt_q <= '0;
                        if (rw_q) begin
                            tx_q  <= rd_next;
                            oe_q  <= ~rd_next[BYTE_W-1];
                            idx_q <= idx_inc;
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                    if (scl_fall) begin
                        if (bit_full) begin
                            oe_q <= 1'b0;
                        end else begin
                            oe_q <= ~tx_q[BYTE_W-2];
                            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    if (scl_fall) begin
                        bitcnt_q <= '0;
                        if (mack_q) begin
                            tx_q  <= rd_next;
                            oe_q  <= ~rd_next[BYTE_W-1];
                            idx_q <= idx_inc;
                        end
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe_o = oe_q;
    assign wiper0_o = wq[0];
    assign wiper1_o = wq[1];
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk
    import wiper_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              stop_evt,
    input logic              sda_oe_o,
    input logic [BYTE_W-1:0] wiper0_o,
    input logic [BYTE_W-1:0] wiper1_o,
    input bus_state_e        state_q
);
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (wiper0_o == 8'h00 && wiper1_o == 8'h00 && !sda_oe_o));

    a_r13_oe_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl);

    a_r13_wiper_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper0_o != $past(wiper0_o) || wiper1_o != $past(wiper1_o)) |-> !scl_lvl);

    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe_o && state_q == ST_IDLE));

    a_r8_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe_o);
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_evt(stop_evt),
    .sda_oe_o(sda_oe_o), .wiper0_o(wiper0_o), .wiper1_o(wiper1_o),
    .state_q(state_q)
);

// File: tb/dual_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_tb_top;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic sda_oe;
    logic [7:0] w0, w1;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int edge_bad = 0;

    always #4 clk = ~clk;

    dual_wiper_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel_i(pins), .sda_oe_o(sda_oe), .wiper0_o(w0), .wiper1_o(w1)
    );

    // R13: enable only moves while the master holds the clock low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) edge_bad++;
        oe_prev <= sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq();
            d = {d[6:0], sda_line};
            wq(); scl_m = 1'b0;
        end
        wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] ctrl(input logic [2:0] a, input logic rd);
        return {4'b0101, a, rd};
    endfunction

    task automatic t_reset();
        chk("R7 wiper0", w0, 8'h00);
        chk("R7 wiper1", w1, 8'h00);
        chk("R7 oe", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_address();
        logic a;
        m_start(); m_wbyte(ctrl(3'b101, 1'b0), a); chk("R2 match ack", {7'd0, a}, 8'h01); m_stop();
        m_start(); m_wbyte(8'h7A, a); chk("R2 bad id nack", {7'd0, a}, 8'h00);
        m_wbyte(8'hA9, a); chk("R2 ignored after mismatch", {7'd0, a}, 8'h00); m_stop();
        m_start(); m_wbyte(ctrl(3'b011, 1'b0), a); chk("R3 wrong pins nack", {7'd0, a}, 8'h00); m_stop();
        pins = 3'b011;
        m_start(); m_wbyte(ctrl(3'b011, 1'b0), a); chk("R3 live pins ack", {7'd0, a}, 8'h01); m_stop();
        pins = 3'b101;
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] d0, input int n,
                      input logic [7:0] d1, input logic [7:0] d2);
        logic a;
        m_start(); m_wbyte(ctrl(pins, 1'b0), a); m_wbyte(cmd, a);
        if (n > 0) m_wbyte(d0, a);
        if (n > 1) m_wbyte(d1, a);
        if (n > 2) begin
            m_wbyte(d2, a);
            chk("R9 extra byte ack", {7'd0, a}, 8'h01);
        end
        m_stop();
    endtask

    task automatic t_writes();
        wr(8'hA9, 8'h3C, 1, 8'h00, 8'h00);
        chk("R5 A9 wiper0", w0, 8'h3C); chk("R5 A9 wiper1 kept", w1, 8'h00);
        wr(8'hA9, 8'h11, 2, 8'h22, 8'h00);
        chk("R6 A9 wiper0", w0, 8'h11); chk("R6 A9 second byte wiper1", w1, 8'h22);
        wr(8'hAA, 8'h5A, 1, 8'h00, 8'h00);
        chk("R5 AA wiper1", w1, 8'h5A); chk("R5 AA wiper0 kept", w0, 8'h11);
        wr(8'hAF, 8'hC3, 1, 8'h00, 8'h00);
        chk("R5 AF wiper0", w0, 8'hC3); chk("R5 AF wiper1", w1, 8'hC3);
        wr(8'hA9, 8'h01, 3, 8'h02, 8'h03);
        chk("R9 wiper0", w0, 8'h01); chk("R9 wiper1", w1, 8'h02);
    endtask

    task automatic t_badcmd();
        logic a;
        m_start(); m_wbyte(ctrl(pins, 1'b0), a); m_wbyte(8'hA8, a);
        chk("R8 unknown cmd nack", {7'd0, a}, 8'h00);
        m_wbyte(8'h77, a); chk("R8 later byte nack", {7'd0, a}, 8'h00);
        m_stop();
        chk("R8 wiper0 kept", w0, 8'h01); chk("R8 wiper1 kept", w1, 8'h02);
    endtask

    task automatic t_stop_mid();
        logic a;
        m_start(); m_wbyte(ctrl(pins, 1'b0), a); m_wbyte(8'hAA, a); m_stop();
        m_wbyte(8'h55, a);
        chk("R1 byte after stop nack", {7'd0, a}, 8'h00);
        chk("R1 wiper1 kept", w1, 8'h02);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        wr(8'hA9, 8'h96, 2, 8'h69, 8'h00);
        m_start(); m_wbyte(ctrl(pins, 1'b1), a); chk("R2 read ack", {7'd0, a}, 8'h01);
        m_rbyte(1'b1, d); chk("R10 first byte wiper0", d, 8'h96);
        m_rbyte(1'b1, d); chk("R10 second byte wiper1", d, 8'h69);
        m_rbyte(1'b0, d); chk("R10 third byte fill", d, 8'hFF);
        chk("R11 released after nack", {7'd0, sda_oe}, 8'h00);
        m_stop();
        m_start(); m_wbyte(ctrl(pins, 1'b1), a);
        m_rbyte(1'b0, d); chk("R4 msb first wiper0", d, 8'h96);
        m_rbyte(1'b1, d); chk("R11 silent after nack", d, 8'hFF);
        m_stop();
    endtask

    task automatic t_rstart();
        logic a;
        logic [7:0] d;
        m_start(); m_wbyte(ctrl(pins, 1'b0), a); m_wbyte(8'hAF, a);
        m_start(); m_wbyte(ctrl(pins, 1'b1), a);
        chk("R12 control after repeated start", {7'd0, a}, 8'h01);
        m_rbyte(1'b0, d); chk("R12 read after repeated start", d, 8'h96);
        m_stop();
        chk("R12 wiper1 kept", w1, 8'h69);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wq();
        t_address();
        t_writes();
        t_badcmd();
        t_stop_mid();
        t_read();
        t_rstart();
        checks++;
        if (edge_bad != 0) begin
            fails++;
            $display("FAIL R13: actual %0d changes with clock high expected 0", edge_bad);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule